// File: doc/BRIEF.md
# Single-Channel Triggered Transfer Sequencer

This block is one channel of a data-movement engine. Once armed, it waits for a trigger pulse and then moves data from a source address to a destination address. Each move is a read request followed at once by a write request on a simple single-cycle memory port. Four transfer modes decide how many moves one trigger causes and whether the channel stays armed afterwards. On each side the address can stay fixed, step up or step down. Moves are either 16-bit words or single bytes; a byte is taken from, and placed into, the half of a word that the address least significant bit selects.

The base addresses and the block count come from the configuration inputs. A `load_i` pulse copies them into internal reload registers and into the working address and counter registers. When a transaction ends, the working registers are refilled from the reload registers in the repeating modes, and in the single-run modes when `reload_i` is set. A guard outside the block can stop the channel at any time through `abort_i`. The block reports activity on `busy_o` and marks the end of each transaction with a one-cycle `done_o` pulse.

Top module: `xfer_seq_chan`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are low, and the channel is disarmed until `arm_i` is pulsed.
- R2: `mode_i`=0 (single): a trigger on an armed idle channel causes exactly one move, and then the channel disarms itself.
- R3: `mode_i`=1 (block): a trigger causes back-to-back moves with no idle cycle between them, as many as the loaded count, and then the channel disarms itself. A block that starts with the counter at 0 performs one move.
- R4: `mode_i`=2 (repeating single): each trigger causes one move, the channel stays armed, and each move uses the reloaded base addresses.
- R5: `mode_i`=3 (repeating block): each trigger causes a full counted block, the channel stays armed, and addresses and count are restored after every block.
- R6: In modes 0 and 1, with `reload_i`=1 the next run after re-arming starts again from the loaded bases and count. With `reload_i`=0 it continues from the stepped addresses, and the counter is left at 0.
- R7: Address mode per side (`src_am_i`/`dst_am_i`): 0 = fixed, 1 = increment, 2 = decrement, 3 = fixed. A stepping address moves by 1 for byte moves and by 2 for word moves after every move.
- R8: `byte_i`=0 selects word moves (the data written equals the word read, and `mem_be_o`=2'b11). `byte_i`=1 selects byte moves: the source byte is `mem_rdata_i[15:8]` when the source address bit 0 is 1, else `[7:0]`. It is written replicated in both halves, with `mem_be_o`=2'b10 when the destination address bit 0 is 1, else 2'b01.
- R9: A trigger that arrives while a move sequence is busy is held as one pending trigger and served after the sequence ends. Any further trigger that arrives while one is pending is dropped.
- R10: `abort_i` returns the block to idle on the next cycle with no `done_o`. It clears a pending trigger and disarms the channel.
- R11: `done_o` is high for one cycle, the cycle after the final write of each transaction, and `busy_o` is low in that cycle.
- R12: Triggers are ignored while the channel is disarmed.
- R13: The memory port carries one request per cycle, only while `busy_o` is high. A read (`mem_we_o`=0, at the source address) is always followed in the next cycle by a write (`mem_we_o`=1, at the destination address), unless an abort intervenes. Read data is taken in the same cycle as the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Copy bases and count into the reload and working registers |
| arm_i | input | 1 | Arm the channel |
| abort_i | input | 1 | Stop the sequence and disarm the channel |
| trig_i | input | 1 | Trigger pulse |
| mode_i | input | 2 | Transfer mode (R2 to R5) |
| reload_i | input | 1 | Restore the registers after a transaction in modes 0 and 1 |
| byte_i | input | 1 | 1 = byte moves, 0 = word moves |
| src_am_i | input | 2 | Source address mode |
| dst_am_i | input | 2 | Destination address mode |
| src_base_i | input | AW | Source base address |
| dst_base_i | input | AW | Destination base address |
| count_i | input | CW | Moves per block |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 2 | Byte enables for a write |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, returned in the same cycle as the read request |
| busy_o | output | 1 | A move sequence is in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The assertions assume that the mode, size, reload and address-mode inputs stay constant while a sequence runs, and that `load_i` and `arm_i` are only pulsed while the channel is idle. The bench changes the configuration only after a run has settled, with the channel idle. It keeps the source addresses in the lower half of its 64-word memory and the destination addresses in the upper half, so that a write never changes data a later read expects. The counts and starting addresses are chosen so that no stepping side wraps past address zero.

// File: rtl/xs_pkg.sv
package xs_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        XM_SINGLE     = 2'd0,
        XM_BLOCK      = 2'd1,
        XM_RPT_SINGLE = 2'd2,
        XM_RPT_BLOCK  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0]        be;
        logic [DATA_W-1:0] data;
    } lane_t;

    function automatic logic mode_repeats(xfer_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_counted(xfer_mode_e m);
        return m[0];
    endfunction

    // pick the addressed byte out of a word, or pass the word through
    function automatic logic [DATA_W-1:0] extract_rd(logic byte_sz, logic lsb,
                                                     logic [DATA_W-1:0] w);
        if (!byte_sz) return w;
        return lsb ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    function automatic lane_t format_wr(logic byte_sz, logic lsb,
                                        logic [DATA_W-1:0] held);
        lane_t r;
        if (!byte_sz) begin
            r.be   = 2'b11;
            r.data = held;
        end else begin
            r.be   = lsb ? 2'b10 : 2'b01;
            r.data = {held[7:0], held[7:0]};
        end
        return r;
    endfunction
endpackage

// File: rtl/xs_addr_unit.sv
module xs_addr_unit
    import xs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          restore,
    input  logic [AW-1:0] restore_val,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic          byte_sz,
    output logic [AW-1:0] addr
);
    addr_mode_e    am;
    logic [AW-1:0] incr;

    assign am   = addr_mode_e'(mode);
    assign incr = byte_sz ? AW'(1) : AW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (restore) begin
            addr <= restore_val;
        end else if (step) begin
            case (am)
                AM_INC:  addr <= addr + incr;
                AM_DEC:  addr <= addr - incr;
                default: addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/xs_lane.sv
module xs_lane
    import xs_pkg::*;
(
    input  logic              byte_sz,
    input  logic              src_lsb,
    input  logic              dst_lsb,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] held,
    output logic [DATA_W-1:0] rd_pick,
    output lane_t             wr
);
    always_comb begin
        rd_pick = extract_rd(byte_sz, src_lsb, rdata);
        wr      = format_wr(byte_sz, dst_lsb, held);
    end
endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl
    import xs_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          arm,
    input  logic          abort,
    input  logic          trig,
    input  xfer_mode_e    mode,
    input  logic          reload,
    input  logic [CW-1:0] cnt_load,
    input  logic [CW-1:0] cnt_restore,
    output seq_state_e    state,
    output logic          step,
    output logic          restore,
    output logic          done
);
    logic          armed_q;
    logic          pend_q;
    logic [CW-1:0] remain_q;
    logic          last_xfer;
    logic          finish;

    assign last_xfer = !mode_counted(mode) || (remain_q <= CW'(1));
    assign finish    = (state == ST_WRITE) && last_xfer && !abort;
    assign restore   = finish && (reload || mode_repeats(mode));
    assign step      = (state == ST_WRITE) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            armed_q  <= 1'b0;
            pend_q   <= 1'b0;
            remain_q <= '0;
            done     <= 1'b0;
        end else if (abort) begin
            state   <= ST_IDLE;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (load) remain_q <= cnt_load;
            if (arm) armed_q <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (armed_q && (trig || pend_q)) begin
                        state  <= ST_READ;
                        pend_q <= 1'b0;
                    end
                end
                ST_READ: begin
                    state <= ST_WRITE;
                    if (trig) pend_q <= 1'b1;
                end
                ST_WRITE: begin
                    if (trig) pend_q <= 1'b1;
                    if (last_xfer) begin
                        state <= ST_IDLE;
                        if (restore) remain_q <= cnt_restore;
                        else if (mode_counted(mode)) remain_q <= '0;
                        if (!mode_repeats(mode)) begin
                            armed_q <= 1'b0;
                            pend_q  <= 1'b0;
                        end
                    end else begin
                        state    <= ST_READ;
                        remain_q <= remain_q - CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xfer_seq_chan.sv
module xfer_seq_chan
    import xs_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          arm_i,
    input  logic          abort_i,
    input  logic          trig_i,
    input  logic [1:0]    mode_i,
    input  logic          reload_i,
    input  logic          byte_i,
    input  logic [1:0]    src_am_i,
    input  logic [1:0]    dst_am_i,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    input  logic [CW-1:0] count_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [1:0]    mem_be_o,
    output logic [15:0]   mem_wdata_o,
    input  logic [15:0]   mem_rdata_i,
    output logic          busy_o,
    output logic          done_o
);
    localparam int DW     = DATA_W;
    localparam int NSIDES = 2;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
    } reload_t;

    reload_t    rl_q;
    seq_state_e st;
    logic       step, restore;
    xfer_mode_e mode;

    logic [NSIDES-1:0][AW-1:0] side_load, side_rest, side_addr;
    logic [NSIDES-1:0][1:0]    side_mode;

    logic [DW-1:0] hold_q, rd_pick;
    lane_t         wr_lane;

    assign mode = xfer_mode_e'(mode_i);

    always_ff @(posedge clk) begin
        if (rst)         rl_q <= '0;
        else if (load_i) rl_q <= '{src: src_base_i, dst: dst_base_i, cnt: count_i};
    end

    xs_ctrl #(.CW(CW)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .load        (load_i),
        .arm         (arm_i),
        .abort       (abort_i),
        .trig        (trig_i),
        .mode        (mode),
        .reload      (reload_i),
        .cnt_load    (count_i),
        .cnt_restore (rl_q.cnt),
        .state       (st),
        .step        (step),
        .restore     (restore),
        .done        (done_o)
    );

    // side 0 = source, side 1 = destination
    assign side_load = {dst_base_i, src_base_i};
    assign side_rest = {rl_q.dst, rl_q.src};
    assign side_mode = {dst_am_i, src_am_i};

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        xs_addr_unit #(.AW(AW)) addr_i (
            .clk         (clk),
            .rst         (rst),
            .load        (load_i),
            .load_val    (side_load[s]),
            .restore     (restore),
            .restore_val (side_rest[s]),
            .step        (step),
            .mode        (side_mode[s]),
            .byte_sz     (byte_i),
            .addr        (side_addr[s])
        );
    end

    xs_lane lane_i (
        .byte_sz (byte_i),
        .src_lsb (side_addr[0][0]),
        .dst_lsb (side_addr[1][0]),
        .rdata   (mem_rdata_i),
        .held    (hold_q),
        .rd_pick (rd_pick),
        .wr      (wr_lane)
    );

    always_ff @(posedge clk) begin
        if (rst)                hold_q <= '0;
        else if (st == ST_READ) hold_q <= rd_pick;
    end

    always_comb begin
        busy_o      = (st != ST_IDLE);
        mem_req_o   = busy_o;
        mem_we_o    = (st == ST_WRITE);
        mem_addr_o  = mem_we_o ? side_addr[1] : side_addr[0];
        mem_be_o    = mem_we_o ? wr_lane.be : 2'b11;
        mem_wdata_o = mem_we_o ? wr_lane.data : '0;
    end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       abort_i,
    input logic       byte_i,
    input logic       mem_req_o,
    input logic       mem_we_o,
    input logic [1:0] mem_be_o,
    input logic       busy_o,
    input logic       done_o
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && !mem_req_o));

    p_read_then_write_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_we_o && !abort_i) |=> (mem_req_o && mem_we_o));

    p_req_only_busy_r13: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> busy_o);

    p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_after_write_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(mem_req_o && mem_we_o) && !busy_o));

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!busy_o && !done_o));

    p_byte_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && byte_i) |-> ($countones(mem_be_o) == 1));

    p_word_lane_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && !byte_i) |-> (mem_be_o == 2'b11));
endmodule

bind xfer_seq_chan xfer_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .abort_i   (abort_i),
    .byte_i    (byte_i),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .mem_be_o  (mem_be_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/xfer_seq_chan_tb.sv
module xfer_seq_chan_tb_top;
    localparam int AW  = 16;
    localparam int CW  = 8;
    localparam int BLK = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_i = 0, arm_i = 0, abort_i = 0, trig_i = 0;
    logic [1:0] mode_i = 0, src_am_i = 0, dst_am_i = 0;
    logic reload_i = 0, byte_i = 0;
    logic [AW-1:0] src_base_i = 0, dst_base_i = 0;
    logic [CW-1:0] count_i = 0;
    logic mem_req_o, mem_we_o, busy_o, done_o;
    logic [AW-1:0] mem_addr_o;
    logic [1:0] mem_be_o;
    logic [15:0] mem_wdata_o, mem_rdata_i;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] mem [64];
    logic [AW-1:0] wa [64];
    logic [AW-1:0] ra [64];
    logic [15:0]   wd [64];
    logic [1:0]    wb [64];
    int            wc [64];
    int            dc [16];
    int nw = 0, nr = 0, nd = 0;

    always #5 clk = ~clk;

    xfer_seq_chan #(.AW(AW), .CW(CW)) dut_i (.*);

    function automatic logic [15:0] memval(int i);
        return {8'(i + 64), 8'(i * 3 + 1)};
    endfunction

    assign mem_rdata_i = mem[mem_addr_o[6:1]];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && mem_req_o && mem_we_o) begin
            if (mem_be_o[0]) mem[mem_addr_o[6:1]][7:0]  <= mem_wdata_o[7:0];
            if (mem_be_o[1]) mem[mem_addr_o[6:1]][15:8] <= mem_wdata_o[15:8];
            if (nw < 64) begin
                wa[nw] <= mem_addr_o; wd[nw] <= mem_wdata_o;
                wb[nw] <= mem_be_o;   wc[nw] <= cyc;
            end
            nw <= nw + 1;
        end
        if (!rst && mem_req_o && !mem_we_o) begin
            if (nr < 64) ra[nr] <= mem_addr_o;
            nr <= nr + 1;
        end
        if (!rst && done_o) begin
            if (nd < 16) dc[nd] <= cyc;
            nd <= nd + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        nw = 0; nr = 0; nd = 0;
    endtask

    task automatic pulse_load(); @(negedge clk); load_i = 1; @(negedge clk); load_i = 0; endtask
    task automatic pulse_arm();  @(negedge clk); arm_i = 1;  @(negedge clk); arm_i = 0;  endtask
    task automatic pulse_trig(); @(negedge clk); trig_i = 1; @(negedge clk); trig_i = 0; endtask
    task automatic idle(int n); repeat (n) @(negedge clk); endtask

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] am,
                                               logic by, int k);
        int st = by ? 1 : 2;
        case (am)
            2'd1: return b + AW'(st * k);
            2'd2: return b - AW'(st * k);
            default: return b;
        endcase
    endfunction

    function automatic logic [15:0] exp_data(logic [AW-1:0] sa, logic by);
        logic [15:0] w = memval(int'(sa[6:1]));
        if (!by) return w;
        return sa[0] ? {w[15:8], w[15:8]} : {w[7:0], w[7:0]};
    endfunction

    // one configuration: two runs, with a disarmed trigger between them for single-run modes
    task automatic run_cfg(logic [1:0] md, logic rl, logic by, logic [1:0] sam, logic [1:0] dam);
        int blk, ntot, nfirst, bad_a, bad_d, bad_gap;
        logic rep;
        mode_i = md; reload_i = rl; byte_i = by; src_am_i = sam; dst_am_i = dam;
        src_base_i = by ? 16'h0021 : 16'h0020;
        dst_base_i = by ? 16'h0061 : 16'h0060;
        count_i = CW'(BLK);
        rep = md[1];
        blk = md[0] ? BLK : 1;
        clear_log();
        pulse_load(); pulse_arm();
        pulse_trig(); idle(16);
        nfirst = nw;
        if (!rep) begin
            pulse_trig(); idle(8);
            chk(nw == nfirst, "R12", "writes from trigger while disarmed", nw, nfirst);
            pulse_arm();
        end
        pulse_trig(); idle(16);
        ntot = (rep || rl) ? 2 * blk : blk + 1;
        chk(nfirst == blk, md[0] ? (rep ? "R5" : "R3") : (rep ? "R4" : "R2"),
            "moves in first run", nfirst, blk);
        chk(nw == ntot, rep ? "R4_R5" : "R6", "moves over two runs", nw, ntot);
        chk(nr == ntot, "R13", "read requests", nr, ntot);
        chk(nd == 2, "R11", "done pulses", nd, 2);
        if (nw == ntot && nd == 2) begin
            bad_a = 0; bad_d = 0; bad_gap = 0;
            for (int j = 0; j < ntot; j++) begin
                int k;
                logic [AW-1:0] sa, da;
                logic [1:0] eb;
                if (j < blk) k = j;
                else if (rep || rl) k = j - blk;
                else k = j;
                sa = exp_addr(src_base_i, sam, by, k);
                da = exp_addr(dst_base_i, dam, by, k);
                eb = by ? (da[0] ? 2'b10 : 2'b01) : 2'b11;
                if (ra[j] != sa || wa[j] != da) bad_a++;
                if (wd[j] != exp_data(sa, by) || wb[j] != eb) bad_d++;
                if (j > 0 && j != blk && (wc[j] - wc[j-1]) != 2) bad_gap++;
            end
            chk(bad_a == 0, "R7", "address mismatches", bad_a, 0);
            chk(bad_d == 0, "R8", "data or byte-enable mismatches", bad_d, 0);
            chk(bad_gap == 0, "R3", "gaps inside a block", bad_gap, 0);
            chk(dc[0] == wc[blk-1] + 1, "R11", "first done cycle", dc[0], wc[blk-1] + 1);
            chk(dc[1] == wc[ntot-1] + 1, "R11", "second done cycle", dc[1], wc[ntot-1] + 1);
        end
        if (rep) begin
            // disarm the repeating channel through abort before the next configuration
            @(negedge clk); abort_i = 1; @(negedge clk); abort_i = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = memval(i);
        idle(3);
        chk(busy_o == 0, "R1", "busy after reset", int'(busy_o), 0);
        chk(done_o == 0, "R1", "done after reset", int'(done_o), 0);
        chk(mem_req_o == 0, "R1", "request after reset", int'(mem_req_o), 0);
        rst = 0;
        idle(2);
        chk(mem_req_o == 0 && busy_o == 0, "R1", "idle after reset release",
            int'(busy_o), 0);
        // R12: unarmed channel ignores triggers
        mode_i = 2'd1; count_i = CW'(BLK); src_base_i = 16'h20; dst_base_i = 16'h60;
        clear_log(); pulse_load(); pulse_trig(); idle(10);
        chk(nw == 0, "R12", "writes before arming", nw, 0);

        for (int md = 0; md < 4; md++)
            for (int rl = 0; rl < 2; rl++)
                for (int by = 0; by < 2; by++)
                    for (int sam = 0; sam < 3; sam++)
                        for (int dam = 0; dam < 3; dam++)
                            run_cfg(2'(md), 1'(rl), 1'(by), 2'(sam), 2'(dam));

        // R9: pending trigger latched once, extra one dropped
        mode_i = 2'd2; reload_i = 0; byte_i = 0; src_am_i = 2'd1; dst_am_i = 2'd1;
        src_base_i = 16'h20; dst_base_i = 16'h60;
        clear_log(); pulse_load(); pulse_arm();
        @(negedge clk); trig_i = 1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); trig_i = 0;
        idle(12);
        chk(nw == 2, "R9", "moves from one trigger plus held triggers", nw, 2);
        chk(nd == 2, "R9", "done pulses with a pending trigger", nd, 2);
        @(negedge clk); abort_i = 1; @(negedge clk); abort_i = 0;

        // R10: abort in the middle of a block
        mode_i = 2'd1; count_i = CW'(5);
        clear_log(); pulse_load(); pulse_arm();
        @(negedge clk); trig_i = 1;
        @(negedge clk); trig_i = 0;
        @(negedge clk);
        @(negedge clk); abort_i = 1; trig_i = 1;
        @(negedge clk); abort_i = 0; trig_i = 0;
        chk(busy_o == 0, "R10", "busy after abort", int'(busy_o), 0);
        idle(10);
        chk(nw == 1, "R10", "writes after abort", nw, 1);
        chk(nd == 0, "R10", "done pulses after abort", nd, 0);
        pulse_trig(); idle(10);
        chk(nw == 1, "R10", "writes from trigger after abort", nw, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule